// File: doc/BRIEF.md
# Store Buffer Drain Controller

This block empties a FIFO store queue into a direct-mapped write-back cache. It works only on the entry at the head of the queue. Each cycle it drives the line index of that store to the cache and compares the returned tag, line-valid bit and data-present bit against the store's address. The cache lookup is combinational, so the comparison happens in the same cycle.

There are three outcomes. On a tag hit with the line data present, the store's word is written into the cache with its byte enables, and the head is popped in the same cycle. On a tag hit while the line data is still on its way, nothing happens and the store is tried again next cycle. On a tag miss the store is not allocated. Instead it is captured into a registered word-write request to memory, and the head is popped only when that request's valid/ready handshake completes.

Address fields with the default parameters (32-bit byte address, 32-bit words, 4 words per line, 16 lines) are as follows. Bits [1:0] select the byte, [3:2] select the word, [7:4] give the line index, and [31:8] are the tag.

Top module: `sb_drain`

## Requirements
- R1: After reset no memory request is pending (`mem_valid` low), and with an empty queue `sq_pop` and `wr_en` are low.
- R2: While `sq_valid` is low, the block issues no cache write, starts no memory request and pops nothing, whatever the lookup returns.
- R3: When the head's tag equals `lk_tag`, `lk_valid` is 1 and `lk_present` is 1 (and no memory request is pending), the block does three things in that same cycle. It raises `wr_en` with `wr_idx` = address bits [7:4], `wr_word` = bits [3:2], and `wr_data`/`wr_be` equal to the head's data and byte enables. It pops the head. `wr_en` also commands the cache to set that line's dirty bit.
- R4: On a tag hit with `lk_present` at 0, the block writes nothing, pops nothing and requests nothing. It retries every cycle and performs the R3 write in the first cycle that `lk_present` is 1.
- R5: On a tag miss (tag differs or `lk_valid` is 0), the block issues no cache write in that cycle. In the next cycle it raises `mem_valid` with `mem_addr`, `mem_data` and `mem_be` equal to the head's address, data and byte enables.
- R6: While `mem_valid` is high and `mem_ready` is low, the request fields hold steady and nothing is popped. In a cycle with both high, `sq_pop` is high. `mem_valid` is low in the following cycle.
- R7: While a memory request is pending, no cache write is issued and no further request is started, even if the lookup now reports a hit.
- R8: At most one entry is popped per cycle, and consecutive hits at the head retire one per cycle in queue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sq_valid | input | 1 | Store queue head holds an entry |
| sq_addr | input | ADDR_W | Byte address of the head store |
| sq_data | input | DATA_W | Store data word |
| sq_be | input | DATA_W/8 | Store byte enables |
| sq_pop | output | 1 | Remove the head entry this cycle |
| lk_idx | output | IDX_W | Line index driven to the cache lookup |
| lk_tag | input | TAG_W | Tag stored at that line |
| lk_valid | input | 1 | Line holds a valid tag |
| lk_present | input | 1 | Line data has arrived |
| wr_en | output | 1 | Write word into cache and set line dirty |
| wr_idx | output | IDX_W | Line index of the write |
| wr_word | output | WORD_B | Word within the line |
| wr_data | output | DATA_W | Write data |
| wr_be | output | DATA_W/8 | Write byte enables |
| mem_valid | output | 1 | Memory word-write request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | ADDR_W | Request address |
| mem_data | output | DATA_W | Request data |
| mem_be | output | DATA_W/8 | Request byte enables |

## Verification
Several rules are checked by the assertions on every cycle:
- every pop is matched by a cache write or a completed memory handshake;
- a pending request holds its fields until it is accepted, and blocks cache writes;
- a stalled hit on missing data does nothing;
- a miss raises a request carrying the head's address on the next cycle.

Some behaviour only the bench's scenarios can show:
- the exact index and word fields sliced from the address, and the data and byte enables that reach the cache;
- the retry that completes once the line data arrives;
- queue-order retirement across consecutive heads.

// File: rtl/sb_drain.sv
module sb_drain #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 16,
  parameter int LINE_WORDS = 4,
  localparam int BE_W   = DATA_W / 8,
  localparam int BYTE_B = $clog2(BE_W),
  localparam int WORD_B = $clog2(LINE_WORDS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_LO = BYTE_B + WORD_B + IDX_W,
  localparam int TAG_W  = ADDR_W - TAG_LO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sq_valid,
  input  logic [ADDR_W-1:0] sq_addr,
  input  logic [DATA_W-1:0] sq_data,
  input  logic [BE_W-1:0]   sq_be,
  output logic              sq_pop,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic              lk_valid,
  input  logic              lk_present,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [WORD_B-1:0] wr_word,
  output logic [DATA_W-1:0] wr_data,
  output logic [BE_W-1:0]   wr_be,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [BE_W-1:0]   mem_be
);
  logic              busy;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_data;
  logic [BE_W-1:0]   q_be;
  logic              tag_hit, act;

  assign lk_idx  = sq_addr[TAG_LO-1 -: IDX_W];
  assign tag_hit = lk_valid && (lk_tag == sq_addr[ADDR_W-1:TAG_LO]);
  assign act     = sq_valid && !busy;

  assign wr_en   = act && tag_hit && lk_present;
  assign wr_idx  = lk_idx;
  assign wr_word = sq_addr[BYTE_B +: WORD_B];
  assign wr_data = sq_data;
  assign wr_be   = sq_be;

  assign mem_valid = busy;
  assign mem_addr  = q_addr;
  assign mem_data  = q_data;
  assign mem_be    = q_be;

  assign sq_pop = wr_en || (busy && mem_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) busy <= 1'b0;
    else if (busy) begin
      if (mem_ready) busy <= 1'b0;
    end else if (act && !tag_hit) busy <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_addr <= '0;
      q_data <= '0;
      q_be   <= '0;
    end else if (act && !tag_hit) begin
      q_addr <= sq_addr;
      q_data <= sq_data;
      q_be   <= sq_be;
    end
  end
endmodule

// File: rtl/sb_drain_chk.sv
module sb_drain_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINES      = 16,
  parameter int LINE_WORDS = 4,
  localparam int BE_W   = DATA_W / 8,
  localparam int TAG_LO = $clog2(BE_W) + $clog2(LINE_WORDS) + $clog2(LINES),
  localparam int TAG_W  = ADDR_W - TAG_LO
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sq_valid,
  input logic [ADDR_W-1:0] sq_addr,
  input logic              sq_pop,
  input logic [TAG_W-1:0]  lk_tag,
  input logic              lk_valid,
  input logic              lk_present,
  input logic              wr_en,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic [BE_W-1:0]   mem_be
);
  logic hit;
  assign hit = lk_valid && (lk_tag == sq_addr[ADDR_W-1:TAG_LO]);

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !mem_valid);

  // R2
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sq_valid |-> (!sq_pop && !wr_en));

  // R3
  pop_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_pop |-> (wr_en || (mem_valid && mem_ready)));

  // R4
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_valid && !mem_valid && hit && !lk_present) |-> (!sq_pop && !wr_en) ##1 !mem_valid);

  // R5
  miss_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_valid && !mem_valid && !hit) |=> (mem_valid && mem_addr == $past(sq_addr)));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)));

  // R6
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> !mem_valid);

  // R7
  no_write_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !wr_en);
endmodule

bind sb_drain sb_drain_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .LINE_WORDS(LINE_WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sq_valid(sq_valid), .sq_addr(sq_addr), .sq_pop(sq_pop),
  .lk_tag(lk_tag), .lk_valid(lk_valid), .lk_present(lk_present), .wr_en(wr_en),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_data(mem_data), .mem_be(mem_be)
);

// File: tb/sb_drain_tb.sv
module sb_drain_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, sq_valid, sq_pop, lk_valid, lk_present, wr_en, mem_valid, mem_ready;
  logic [31:0] sq_addr, sq_data, wr_data, mem_addr, mem_data;
  logic [3:0]  sq_be, wr_be, mem_be, lk_idx, wr_idx;
  logic [23:0] lk_tag;
  logic [1:0]  wr_word;

  sb_drain u_dut (
    .clk(clk), .rst_n(rst_n), .sq_valid(sq_valid), .sq_addr(sq_addr), .sq_data(sq_data),
    .sq_be(sq_be), .sq_pop(sq_pop), .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_valid(lk_valid),
    .lk_present(lk_present), .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word),
    .wr_data(wr_data), .wr_be(wr_be), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    logic [23:0] ltag;
    logic        lval;
    logic        miss;
    logic [3:0]  dly;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_1234, 32'hDEAD_BEEF, 4'hF, 24'h000012, 1'b1, 1'b0, 4'd0},
    '{32'hABCD_00F8, 32'h1111_2222, 4'h3, 24'h000012, 1'b1, 1'b1, 4'd0},
    '{32'h0000_12F4, 32'h5A5A_5A5A, 4'h5, 24'h000012, 1'b1, 1'b0, 4'd0},
    '{32'h0000_1208, 32'h7777_0000, 4'hC, 24'h000012, 1'b0, 1'b1, 4'd2},
    '{32'h0FF0_0A0C, 32'hCAFE_F00D, 4'h8, 24'h0FF00B, 1'b1, 1'b1, 4'd3},
    '{32'h0FF0_0B0C, 32'h0BAD_CAFE, 4'hF, 24'h0FF00B, 1'b1, 1'b0, 4'd0}
  };

  int checks = 0, fails = 0;

  task automatic chk(input string r, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, a, e);
    end
  endtask

  task automatic head(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b,
                      input logic [23:0] t, input logic v, input logic p);
    sq_valid = 1'b1; sq_addr = a; sq_data = d; sq_be = b;
    lk_tag = t; lk_valid = v; lk_present = p;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sq_valid = 1'b0; sq_addr = '0; sq_data = '0; sq_be = '0;
    lk_tag = '0; lk_valid = 1'b0; lk_present = 1'b0; mem_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 mem_valid in reset", mem_valid, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 mem_valid after reset", mem_valid, 0);
    chk("R1 sq_pop after reset", sq_pop, 0);
    chk("R1 wr_en after reset", wr_en, 0);

    // R2: empty queue with a hitting lookup
    lk_tag = 24'h000012; lk_valid = 1'b1; lk_present = 1'b1; sq_addr = 32'h0000_1234;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R2 wr_en empty", wr_en, 0);
      chk("R2 sq_pop empty", sq_pop, 0);
      chk("R2 mem_valid empty", mem_valid, 0);
    end

    // Table walk: R3 hits, R5/R6 misses
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      head(VECS[i].addr, VECS[i].data, VECS[i].be, VECS[i].ltag, VECS[i].lval, 1'b1);
      mem_ready = 1'b0;
      #1;
      if (!VECS[i].miss) begin
        chk("R3 wr_en", wr_en, 1);
        chk("R3 sq_pop", sq_pop, 1);
        chk("R3 wr_idx", wr_idx, VECS[i].addr[7:4]);
        chk("R3 wr_word", wr_word, VECS[i].addr[3:2]);
        chk("R3 wr_data", wr_data, VECS[i].data);
        chk("R3 wr_be", wr_be, VECS[i].be);
        @(negedge clk);
        sq_valid = 1'b0;
      end else begin
        chk("R5 no write on miss", wr_en, 0);
        chk("R5 no pop on miss", sq_pop, 0);
        @(negedge clk); #1;
        chk("R5 mem_valid", mem_valid, 1);
        chk("R5 mem_addr", mem_addr, VECS[i].addr);
        chk("R5 mem_data", mem_data, VECS[i].data);
        chk("R5 mem_be", mem_be, VECS[i].be);
        for (int k = 0; k < int'(VECS[i].dly); k++) begin
          @(negedge clk); #1;
          chk("R6 held valid", mem_valid, 1);
          chk("R6 held addr", mem_addr, VECS[i].addr);
          chk("R6 no pop while waiting", sq_pop, 0);
        end
        mem_ready = 1'b1; #1;
        chk("R6 pop on handshake", sq_pop, 1);
        @(negedge clk);
        mem_ready = 1'b0; sq_valid = 1'b0; #1;
        chk("R6 valid dropped", mem_valid, 0);
      end
    end

    // R4: hit while data still arriving, then data arrives
    @(negedge clk);
    head(32'h0000_1230, 32'h0102_0304, 4'hF, 24'h000012, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R4 no write while missing", wr_en, 0);
      chk("R4 no pop while missing", sq_pop, 0);
      @(negedge clk);
      chk("R4 no request while missing", mem_valid, 0);
    end
    lk_present = 1'b1; #1;
    chk("R4 write once present", wr_en, 1);
    chk("R4 pop once present", sq_pop, 1);
    chk("R4 data once present", wr_data, 32'h0102_0304);

    // R8: back-to-back hits retire one per cycle in order
    @(negedge clk);
    head(32'h0000_1200, 32'hAAAA_0001, 4'h1, 24'h000012, 1'b1, 1'b1); #1;
    chk("R8 first pop", sq_pop, 1);
    chk("R8 first data", wr_data, 32'hAAAA_0001);
    @(negedge clk);
    head(32'h0000_1204, 32'hAAAA_0002, 4'h2, 24'h000012, 1'b1, 1'b1); #1;
    chk("R8 second pop", sq_pop, 1);
    chk("R8 second data", wr_data, 32'hAAAA_0002);
    chk("R8 second word", wr_word, 2'd1);

    // R7: lookup turns into a hit while request pending
    @(negedge clk);
    head(32'h0000_3340, 32'h9999_8888, 4'hF, 24'h000012, 1'b1, 1'b1);
    @(negedge clk);
    lk_tag = 24'h000033; #1;
    chk("R7 request pending", mem_valid, 1);
    chk("R7 no write while pending", wr_en, 0);
    chk("R7 no pop while pending", sq_pop, 0);
    @(negedge clk); #1;
    chk("R7 still no write", wr_en, 0);
    mem_ready = 1'b1; #1;
    chk("R7 pop on handshake", sq_pop, 1);
    chk("R7 single retire", wr_en, 0);
    @(negedge clk);
    mem_ready = 1'b0; sq_valid = 1'b0; #1;
    chk("R7 idle after", mem_valid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule